// File: doc/BRIEF.md
# Issue Interlock and Operand Bypass Control

This unit decides, once per cycle, whether the instruction in decode of an in-order fetch/decode/execute/memory/writeback pipeline may issue. It also decides where each of that instruction's source operands comes from. It keeps its own copy of the destination, write and load flags for the instructions in execute, memory and writeback. It also keeps a pending flag per architectural register that marks registers with an outstanding write. Each in-flight stage exposes a path-usable flag.

A source register with no pending write is read from the register file. If a write to it is pending, the youngest in-flight producer of that register supplies the value through its forwarding path. If that path cannot yet carry the value, the instruction stalls. This happens when the producer is a load still in execute. A stalled instruction stays in decode, and an empty slot enters execute. A conditional branch holds instruction fetch from the time it is fetched until it has left execute.

Top module: `hzd_unit`

## Requirements
- R1: After reset every register is treated as written back: a valid decode instruction gets select 2'b00 on both operands, with no stall and no fetch hold.
- R2: Operand select codes are 2'b00 register file, 2'b01 execute-stage result, 2'b10 memory-stage result, 2'b11 writeback-stage result. A consumer directly behind a non-load producer of its source gets 2'b01 and does not stall.
- R3: A consumer two slots behind an ALU producer gets 2'b10. At three slots behind it gets 2'b11. At four slots behind it gets 2'b00.
- R4: A consumer directly behind a load to its source register stalls for exactly one cycle.
- R5: stall_o is raised only for a valid decode instruction. A stalled instruction stays in decode and a bubble enters execute, so after a load-use stall the same consumer gets 2'b10 and not 2'b01.
- R6: When several in-flight producers write the same source register, the youngest one is selected.
- R7: Register 0 never has a pending write: reading it always selects 2'b00 without a stall, even right after an instruction that names it as destination.
- R8: Only read-after-write hazards stall. An instruction whose destination matches a pending write, or whose destination is read by an older instruction, issues without a stall.
- R9: At writeback a register becomes free again only if no younger producer of it is in flight. Otherwise the consumer keeps tracking the younger producer.
- R10: fetch_hold_o is high while a conditional branch is in fetch, in decode or in execute. It drops in the cycle after the branch leaves execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode stage holds an instruction |
| dec_rs1_i | input | RW | First source register |
| dec_rs2_i | input | RW | Second source register |
| dec_rd_i | input | RW | Destination register |
| dec_wr_i | input | 1 | Instruction writes its destination |
| dec_load_i | input | 1 | Instruction is a load |
| dec_branch_i | input | 1 | Instruction is a conditional branch |
| fetch_branch_i | input | 1 | Fetch stage holds a conditional branch |
| stall_o | output | 1 | Hold decode, insert bubble into execute |
| fwd_rs1_o | output | 2 | Operand source select for first source |
| fwd_rs2_o | output | 2 | Operand source select for second source |
| fetch_hold_o | output | 1 | Do not fetch a new instruction |

## Verification
The properties assume that decode inputs stay stable while stall_o is high. They also assume that the bench lets a slot issue exactly when no stall is reported, since the unit's view of the pipeline follows its own issue decision. The directed sequences repeat the stalled instruction unchanged until the stall clears. Between scenarios they drain the pipeline with empty slots, so every scenario starts with all registers free and no branch in flight.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NSTG = 3;  // execute, memory, writeback

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EX  = 2'b01,
    FWD_MEM = 2'b10,
    FWD_WB  = 2'b11
  } fwd_e;

  typedef struct packed {
    logic vld;
    logic wr;
    logic load;
    logic br;
  } stg_t;
endpackage

// File: rtl/hzd_track.sv
module hzd_track
  import hzd_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  stg_t                       in_i,
  input  logic [RW-1:0]              rd_i,
  output stg_t [NSTG-1:0]            flg_o,
  output logic [NSTG-1:0][RW-1:0]    rd_o
);
  stg_t [NSTG-1:0]         flg_q;
  logic [NSTG-1:0][RW-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
      rd_q  <= '0;
    end else begin
      flg_q[0] <= in_i;
      rd_q[0]  <= rd_i;
      for (int k = 1; k < NSTG; k++) begin
        flg_q[k] <= flg_q[k-1];
        rd_q[k]  <= rd_q[k-1];
      end
    end
  end

  assign flg_o = flg_q;
  assign rd_o  = rd_q;
endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [RW-1:0]   clr_rd_i,
  input  logic            set_i,
  input  logic [RW-1:0]   set_rd_i,
  output logic [NREG-1:0] free_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign free_o[r] = 1'b1;
    end else begin : g_bit
      logic free_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               free_q <= 1'b1;
        else if (clr_i && clr_rd_i == RW'(r))      free_q <= 1'b0;  // issue beats writeback
        else if (set_i && set_rd_i == RW'(r))      free_q <= 1'b1;
      end
      assign free_o[r] = free_q;
    end
  end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0]            src_i,
  input  logic                     src_free_i,
  input  stg_t [NSTG-1:0]          flg_i,
  input  logic [NSTG-1:0][RW-1:0]  rd_i,
  input  logic [NSTG-1:0]          path_ok_i,
  output fwd_e                     sel_o,
  output logic                     stall_o
);
  always_comb begin
    sel_o   = FWD_RF;
    stall_o = 1'b0;
    if (src_i != '0 && !src_free_i) begin
      stall_o = 1'b1;
      // oldest first so the youngest hit wins
      for (int k = NSTG - 1; k >= 0; k--) begin
        if (flg_i[k].vld && flg_i[k].wr && rd_i[k] == src_i) begin
          stall_o = !path_ok_i[k];
          sel_o   = path_ok_i[k] ? fwd_e'(2'(k + 1)) : FWD_RF;
        end
      end
    end
  end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_valid_i,
  input  logic [RW-1:0] dec_rs1_i,
  input  logic [RW-1:0] dec_rs2_i,
  input  logic [RW-1:0] dec_rd_i,
  input  logic          dec_wr_i,
  input  logic          dec_load_i,
  input  logic          dec_branch_i,
  input  logic          fetch_branch_i,
  output logic          stall_o,
  output logic [1:0]    fwd_rs1_o,
  output logic [1:0]    fwd_rs2_o,
  output logic          fetch_hold_o
);
  localparam int WB = NSTG - 1;

  stg_t [NSTG-1:0]         stg_flg;
  logic [NSTG-1:0][RW-1:0] stg_rd;
  logic [NSTG-1:0]         path_ok;
  logic [NREG-1:0]         reg_free;
  logic                    issue;
  stg_t                    dec_s;
  logic                    st1, st2;
  fwd_e                    sel1, sel2;
  logic [NSTG-1:0]         younger;
  logic                    wb_set;

  assign issue = dec_valid_i && !stall_o;
  assign dec_s = '{vld: issue, wr: dec_wr_i, load: dec_load_i, br: dec_branch_i};

  hzd_track #(.RW(RW)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (dec_s),
    .rd_i   (dec_rd_i),
    .flg_o  (stg_flg),
    .rd_o   (stg_rd)
  );

  // load data is not usable while the load sits in execute
  for (genvar k = 0; k < NSTG; k++) begin : g_path
    if (k == 0) begin : g_ex
      assign path_ok[k] = stg_flg[k].vld && stg_flg[k].wr && !stg_flg[k].load;
    end else begin : g_late
      assign path_ok[k] = stg_flg[k].vld && stg_flg[k].wr;
    end
  end

  // younger producers of the writeback register keep it pending
  for (genvar k = 0; k < NSTG; k++) begin : g_young
    if (k == WB) begin : g_dec
      assign younger[k] = issue && dec_wr_i && dec_rd_i == stg_rd[WB];
    end else begin : g_inf
      assign younger[k] = stg_flg[k].vld && stg_flg[k].wr && stg_rd[k] == stg_rd[WB];
    end
  end
  assign wb_set = stg_flg[WB].vld && stg_flg[WB].wr && younger == '0;

  hzd_scoreboard #(.NREG(NREG), .RW(RW)) u_sb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (issue && dec_wr_i),
    .clr_rd_i (dec_rd_i),
    .set_i    (wb_set),
    .set_rd_i (stg_rd[WB]),
    .free_o   (reg_free)
  );

  hzd_fwd_sel #(.RW(RW)) u_sel1 (
    .src_i      (dec_rs1_i),
    .src_free_i (reg_free[dec_rs1_i]),
    .flg_i      (stg_flg),
    .rd_i       (stg_rd),
    .path_ok_i  (path_ok),
    .sel_o      (sel1),
    .stall_o    (st1)
  );

  hzd_fwd_sel #(.RW(RW)) u_sel2 (
    .src_i      (dec_rs2_i),
    .src_free_i (reg_free[dec_rs2_i]),
    .flg_i      (stg_flg),
    .rd_i       (stg_rd),
    .path_ok_i  (path_ok),
    .sel_o      (sel2),
    .stall_o    (st2)
  );

  assign stall_o      = dec_valid_i && (st1 || st2);
  assign fwd_rs1_o    = dec_valid_i ? sel1 : FWD_RF;
  assign fwd_rs2_o    = dec_valid_i ? sel2 : FWD_RF;
  assign fetch_hold_o = fetch_branch_i || (dec_valid_i && dec_branch_i) ||
                        (stg_flg[0].vld && stg_flg[0].br);
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int RW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dec_valid_i,
  input logic [RW-1:0] dec_rs1_i,
  input logic [RW-1:0] dec_rs2_i,
  input logic [RW-1:0] dec_rd_i,
  input logic          dec_wr_i,
  input logic          dec_load_i,
  input logic          dec_branch_i,
  input logic          stall_o,
  input logic [1:0]    fwd_rs1_o,
  input logic [1:0]    fwd_rs2_o,
  input logic          fetch_hold_o,
  input logic          ex_vld_i
);
  p_stall_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> dec_valid_i);

  p_bubble_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !ex_vld_i);

  p_load_use_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dec_valid_i && !stall_o && dec_load_i && dec_wr_i && dec_rd_i != '0) &&
     dec_valid_i && dec_rs1_i == $past(dec_rd_i)) |-> stall_o);

  p_alu_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dec_valid_i && !stall_o && !dec_load_i && dec_wr_i && dec_rd_i != '0) &&
     dec_valid_i && dec_rs1_i == $past(dec_rd_i)) |-> fwd_rs1_o == 2'b01);

  p_zero_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && dec_rs1_i == '0 && dec_rs2_i == '0) |->
      (fwd_rs1_o == 2'b00 && fwd_rs2_o == 2'b00));

  p_no_raw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_rs1_i == '0 && dec_rs2_i == '0) |-> !stall_o);

  p_branch_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dec_valid_i && dec_branch_i && !stall_o) |-> fetch_hold_o);
endmodule

bind hzd_unit hzd_unit_chk #(.RW(RW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dec_valid_i  (dec_valid_i),
  .dec_rs1_i    (dec_rs1_i),
  .dec_rs2_i    (dec_rs2_i),
  .dec_rd_i     (dec_rd_i),
  .dec_wr_i     (dec_wr_i),
  .dec_load_i   (dec_load_i),
  .dec_branch_i (dec_branch_i),
  .stall_o      (stall_o),
  .fwd_rs1_o    (fwd_rs1_o),
  .fwd_rs2_o    (fwd_rs2_o),
  .fetch_hold_o (fetch_hold_o),
  .ex_vld_i     (stg_flg[0].vld)
);

// File: tb/hzd_unit_tb.sv
`timescale 1ns/1ps
module hzd_unit_tb;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dec_valid = 1'b0;
  logic [RW-1:0] rs1 = '0, rs2 = '0, rd = '0;
  logic          wr = 1'b0, ld = 1'b0, br = 1'b0, fbr = 1'b0;
  logic          stall, hold;
  logic [1:0]    f1, f2;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2.5 clk = ~clk;

  hzd_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid),
    .dec_rs1_i(rs1), .dec_rs2_i(rs2), .dec_rd_i(rd),
    .dec_wr_i(wr), .dec_load_i(ld), .dec_branch_i(br),
    .fetch_branch_i(fbr), .stall_o(stall), .fwd_rs1_o(f1),
    .fwd_rs2_o(f2), .fetch_hold_o(hold)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one decode slot: drive after negedge, check before posedge, return at next negedge
  task automatic slot(input logic v, input int s1, input int s2, input int d,
                      input logic w, input logic l, input logic b, input logic fb,
                      input logic e_st, input int e1, input int e2, input logic e_h,
                      input string req);
    dec_valid = v; rs1 = RW'(s1); rs2 = RW'(s2); rd = RW'(d);
    wr = w; ld = l; br = b; fbr = fb;
    #1;
    check(req, "stall", int'(stall), int'(e_st));
    check(req, "fwd_rs1", int'(f1), e1);
    check(req, "fwd_rs2", int'(f2), e2);
    check(req, "fetch_hold", int'(hold), int'(e_h));
    @(negedge clk);
  endtask

  task automatic nop(input string req);
    slot(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) nop("drain");
  endtask

  task automatic t_reset();
    nop("R1");
    slot(1, 5, 6, 7, 1, 0, 0, 0, 0, 0, 0, 0, "R1");
    drain();
  endtask

  task automatic t_alu_chain();
    slot(1, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    slot(1, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R2");  // E path
    slot(1, 0, 3, 0, 0, 0, 0, 0, 0, 0, 2, 0, "R3");  // M path
    slot(1, 3, 3, 0, 0, 0, 0, 0, 0, 3, 3, 0, "R3");  // W path
    slot(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");  // written back
    drain();
  endtask

  task automatic t_load_use();
    slot(1, 0, 0, 7, 1, 1, 0, 0, 0, 0, 0, 0, "R4");
    slot(1, 7, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R4");  // stalls
    slot(1, 7, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, "R5");  // bubble in E, load in M
    slot(1, 0, 7, 0, 0, 0, 0, 0, 0, 0, 3, 0, "R4");
    drain();
    slot(1, 0, 0, 8, 1, 1, 0, 0, 0, 0, 0, 0, "R4");
    slot(1, 0, 8, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R4");  // second operand stalls too
    slot(1, 0, 8, 0, 0, 0, 0, 0, 0, 0, 2, 0, "R5");
    drain();
  endtask

  task automatic t_youngest();
    slot(1, 0, 0, 4, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
    slot(1, 0, 0, 4, 1, 0, 0, 0, 0, 0, 0, 0, "R6");
    slot(1, 4, 4, 0, 0, 0, 0, 0, 0, 1, 1, 0, "R6");
    drain();
  endtask

  task automatic t_zero();
    slot(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R7");  // load names r0
    slot(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R7");
    slot(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    drain();
  endtask

  task automatic t_no_false_stall();
    slot(1, 0, 0, 9, 1, 1, 0, 0, 0, 0, 0, 0, "R8");
    slot(1, 1, 2, 9, 1, 0, 0, 0, 0, 0, 0, 0, "R8");  // WAW behind load
    slot(1, 9, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");  // youngest ALU writer
    slot(1, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    slot(1, 0, 0, 10, 1, 0, 0, 0, 0, 0, 0, 0, "R8"); // WAR
    drain();
  endtask

  task automatic t_keep_pending();
    slot(1, 0, 0, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    slot(1, 0, 0, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    nop("R9");
    nop("R9");  // older writer retires here
    slot(1, 5, 5, 0, 0, 0, 0, 0, 0, 3, 3, 0, "R9");
    slot(1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    drain();
  endtask

  task automatic t_branch();
    slot(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R10");
    slot(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 1, "R10");
    slot(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
    slot(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    drain();
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "stall_in_reset", int'(stall), 0);
    check("R1", "hold_in_reset", int'(hold), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alu_chain();
    t_load_use();
    t_youngest();
    t_zero();
    t_no_false_stall();
    t_keep_pending();
    t_branch();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule